// File: doc/BRIEF.md
# Streaming Byte Signature Matcher

This block watches a byte stream and flags any packet that contains one of a small set of fixed byte signatures. A producer presents one byte on `din` and marks it by flipping the level of `adv_tgl`. Each accepted byte enters a short shift window. A toggle handshake suits a slow producer, such as a processor writing a register, because the producer can hold the level between bytes for as long as it likes. It also lets the input run at one byte per clock when the level flips on every cycle.

Every signature rule compares the window at the same time as the others. The results are held in sticky per-rule flags and in one combined flag, and these stay set until `clr` is pulsed between packets. A saturating counter reports how many bytes have been accepted since the last clear. The signatures and their lengths are elaboration parameters. The default rule set holds three rules of up to four bytes each.

Top module: `byte_sig_matcher`

## Requirements
- R1: After reset, `hit` is 0, `rule_hits` is all zeros and `byte_count` is 0.
- R2: A byte is accepted only when the registered `adv_tgl` differs from the level seen one cycle earlier. While `adv_tgl` holds its level, `byte_count` does not change and no rule can fire, whatever `din` does.
- R3: When `adv_tgl` flips on every clock, one byte is accepted per clock. After 8 back-to-back bytes, `byte_count` has already advanced by 7 on the falling edge that follows the rising edge that sampled the 8th byte.
- R4: Rule 0 matches the bytes 0x62, 0x61, 0x64, oldest first. If the last byte and its toggle are sampled on rising edge N, then `hit` and `rule_hits[0]` are still 0 after edges N and N+1, and are 1 after edge N+2.
- R5: A signature is found no matter how many idle clocks separate the toggles that deliver its bytes.
- R6: Rule 1 is 0x65 0x76 0x69 0x6C and rule 2 is 0xDE 0xAD, oldest first. Bit r of `rule_hits` is set only by rule r, and `hit` is set whenever any rule matches.
- R7: `hit` and `rule_hits` stay set after a match until `clr` is sampled high.
- R8: When `clr` is sampled high on the same edge at which a new match would be recorded, the clear wins: `hit`, `rule_hits` and `byte_count` are 0 after that edge.
- R9: After a clear, a rule can fire only on bytes received after that clear. Bytes delivered before the clear never combine with later bytes.
- R10: `byte_count` counts the accepted bytes since the last clear and saturates at 65535.
- R11: A signature's bytes in any other order (for example 0x64 0x61 0x62) do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Byte offered to the window |
| adv_tgl | input | 1 | Level toggle. Each change delivers the byte on `din` |
| clr | input | 1 | Synchronous clear of the flags, the count and the window |
| hit | output | 1 | Sticky combined match flag |
| rule_hits | output | 3 | Sticky per-rule match flags |
| byte_count | output | 16 | Saturating count of bytes accepted since the last clear |

## Verification
A wrong fill level or a bad shift in the window shows up as a missing or spurious `rule_hits` bit two edges after the byte that completes, or should not complete, a signature. A broken edge detector shows up right away in `byte_count`, which either drifts while the toggle is held or falls behind a toggle that flips every clock. A faulty clear shows up one edge later. Either the flags survive the clear, or bytes from before the clear combine with bytes sent after it.

// File: rtl/sigm_pkg.sv
package sigm_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Increment that stops at a ceiling.
  function automatic logic [31:0] sat_inc(logic [31:0] v, logic [31:0] ceil_v);
    return (v >= ceil_v) ? v : v + 32'd1;
  endfunction

  // Count ceiling for a counter of the given width (width at most 32).
  function automatic logic [31:0] count_ceiling(int w);
    logic [63:0] one;
    one = 64'd1;
    return 32'((one << w) - 64'd1);
  endfunction
endpackage

// File: rtl/sigm_adv_detect.sv
module sigm_adv_detect
  import sigm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t din,
  input  logic  adv_tgl,
  output byte_t data_q,
  output logic  step
);
  logic adv_r, adv_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adv_r    <= 1'b0;
      adv_prev <= 1'b0;
      data_q   <= '0;
    end else begin
      adv_r    <= adv_tgl;
      adv_prev <= adv_r;
      data_q   <= din;
    end
  end

  assign step = adv_r ^ adv_prev;
endmodule

// File: rtl/sigm_window.sv
module sigm_window
  import sigm_pkg::*;
#(
  parameter int MAX_LEN = 4,
  localparam int FILL_W = $clog2(MAX_LEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     step,
  input  byte_t                    data_in,
  output logic [MAX_LEN*BYTE_W-1:0] win,
  output logic [FILL_W-1:0]        fill
);
  // Slot 0 holds the newest byte.
  for (genvar k = 0; k < MAX_LEN; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        win[k*BYTE_W +: BYTE_W] <= '0;
      end else if (step) begin
        if (k == 0) win[k*BYTE_W +: BYTE_W] <= data_in;
        else        win[k*BYTE_W +: BYTE_W] <= win[(k-1)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      fill <= '0;
    else if (step && (fill < FILL_W'(MAX_LEN)))
      fill <= fill + 1'b1;
  end
endmodule

// File: rtl/sigm_rule_cmp.sv
module sigm_rule_cmp
  import sigm_pkg::*;
#(
  parameter int MAX_LEN = 4,
  parameter int LEN     = 3,
  parameter logic [MAX_LEN*BYTE_W-1:0] PAT = '0,
  localparam int FILL_W = $clog2(MAX_LEN + 1)
) (
  input  logic [MAX_LEN*BYTE_W-1:0] win,
  input  logic [FILL_W-1:0]        fill,
  output logic                     fire
);
  logic [MAX_LEN-1:0] eq;

  // Pattern byte i is oldest first, so it lines up with slot LEN-1-i.
  for (genvar k = 0; k < MAX_LEN; k++) begin : g_cmp
    if (k < LEN) begin : g_used
      assign eq[k] = (win[k*BYTE_W +: BYTE_W] == PAT[(LEN-1-k)*BYTE_W +: BYTE_W]);
    end else begin : g_unused
      assign eq[k] = 1'b1;
    end
  end

  assign fire = (&eq) && (fill >= FILL_W'(LEN));
endmodule

// File: rtl/sigm_hit_track.sv
module sigm_hit_track
  import sigm_pkg::*;
#(
  parameter int NUM_RULES = 3,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  input  logic [NUM_RULES-1:0] fire,
  output logic                 any_match,
  output logic                 hit,
  output logic [NUM_RULES-1:0] rule_hits,
  output logic [CNT_W-1:0]     byte_count
);
  localparam logic [31:0] CEIL = count_ceiling(CNT_W);

  assign any_match = |fire;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hit        <= 1'b0;
      rule_hits  <= '0;
      byte_count <= '0;
    end else begin
      hit       <= hit | any_match;
      rule_hits <= rule_hits | fire;
      if (step) byte_count <= CNT_W'(sat_inc(32'(byte_count), CEIL));
    end
  end
endmodule

// File: rtl/byte_sig_matcher.sv
module byte_sig_matcher
  import sigm_pkg::*;
#(
  parameter int NUM_RULES = 3,
  parameter int MAX_LEN   = 4,
  parameter int CNT_W     = 16,
  parameter logic [NUM_RULES*MAX_LEN*8-1:0] RULE_BYTES = 96'h0000ADDE_6C697665_00646162,
  parameter logic [NUM_RULES*8-1:0]         RULE_LENS  = 24'h020403
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           din,
  input  logic                 adv_tgl,
  input  logic                 clr,
  output logic                 hit,
  output logic [NUM_RULES-1:0] rule_hits,
  output logic [CNT_W-1:0]     byte_count
);
  localparam int FILL_W = $clog2(MAX_LEN + 1);
  localparam int SLOT_W = MAX_LEN * BYTE_W;

  byte_t                 data_q;
  logic                  step_w;
  logic [SLOT_W-1:0]     win;
  logic [FILL_W-1:0]     fill;
  logic [NUM_RULES-1:0]  fire;
  logic                  any_match_w;

  sigm_adv_detect u_adv (
    .clk(clk), .rst_n(rst_n), .din(din), .adv_tgl(adv_tgl),
    .data_q(data_q), .step(step_w)
  );

  sigm_window #(.MAX_LEN(MAX_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step_w),
    .data_in(data_q), .win(win), .fill(fill)
  );

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    sigm_rule_cmp #(
      .MAX_LEN(MAX_LEN),
      .LEN(int'(RULE_LENS[r*8 +: 8])),
      .PAT(RULE_BYTES[r*SLOT_W +: SLOT_W])
    ) u_cmp (
      .win(win), .fill(fill), .fire(fire[r])
    );
  end

  sigm_hit_track #(.NUM_RULES(NUM_RULES), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step_w), .fire(fire),
    .any_match(any_match_w), .hit(hit), .rule_hits(rule_hits),
    .byte_count(byte_count)
  );
endmodule

// File: rtl/sigm_checker.sv
module sigm_checker #(
  parameter int NUM_RULES = 3,
  parameter int CNT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic                 step,
  input logic                 any_match,
  input logic                 hit,
  input logic [NUM_RULES-1:0] rule_hits,
  input logic [CNT_W-1:0]     byte_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> hit); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!hit && rule_hits == '0 && byte_count == '0)); // R8

  AST_NO_STEP_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(byte_count)); // R2

  AST_STEP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && byte_count != CMAX) |=> byte_count == $past(byte_count) + 1'b1); // R3

  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_count == CMAX && !clr) |=> byte_count == CMAX); // R10

  AST_HIT_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(any_match)); // R4

  AST_FLAG_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (|rule_hits)); // R6
endmodule

bind byte_sig_matcher sigm_checker #(.NUM_RULES(NUM_RULES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .step(step_w), .any_match(any_match_w),
  .hit(hit), .rule_hits(rule_hits), .byte_count(byte_count)
);

// File: tb/byte_sig_matcher_test.sv
module byte_sig_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  din = 8'h00;
  logic        adv_tgl = 1'b0;
  logic        clr = 1'b0;
  logic        hit;
  logic [2:0]  rule_hits;
  logic [15:0] byte_count;

  int total = 0;
  int fails = 0;

  // Bench model: newest byte at index 0.
  logic [7:0] hist [4];
  int         nfill = 0;
  logic [2:0] exp_rh = '0;
  int         exp_cnt = 0;

  always #2.5 clk = ~clk;

  byte_sig_matcher uut (
    .clk(clk), .rst_n(rst_n), .din(din), .adv_tgl(adv_tgl), .clr(clr),
    .hit(hit), .rule_hits(rule_hits), .byte_count(byte_count)
  );

  function automatic int sig_len(int r);
    case (r) 0: return 3; 1: return 4; default: return 2; endcase
  endfunction

  function automatic logic [7:0] sig_byte(int r, int j);
    logic [7:0] s0 [3] = '{8'h62, 8'h61, 8'h64};
    logic [7:0] s1 [4] = '{8'h65, 8'h76, 8'h69, 8'h6C};
    logic [7:0] s2 [2] = '{8'hDE, 8'hAD};
    case (r) 0: return s0[j]; 1: return s1[j]; default: return s2[j]; endcase
  endfunction

  function automatic bit model_match(int r);
    int l = sig_len(r);
    if (nfill < l) return 1'b0;
    for (int j = 0; j < l; j++)
      if (hist[l-1-j] != sig_byte(r, j)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_push(input logic [7:0] b);
    for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = b;
    if (nfill < 4) nfill++;
    if (exp_cnt < 65535) exp_cnt++;
    for (int r = 0; r < 3; r++) if (model_match(r)) exp_rh[r] = 1'b1;
  endtask

  task automatic model_clear();
    nfill = 0; exp_rh = '0; exp_cnt = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input int gap);
    repeat (gap) @(posedge clk);
    @(negedge clk);
    din = b;
    adv_tgl = ~adv_tgl;
    @(posedge clk);
    model_push(b);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(posedge clk);
    @(negedge clk); clr = 1'b0;
    model_clear();
  endtask

  task automatic check_model(input string req);
    check(req, 32'(rule_hits), 32'(exp_rh));
    check(req, 32'(hit), 32'(|exp_rh));
    check(req, 32'(byte_count), 32'(exp_cnt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] alpha [9] = '{8'h62, 8'h61, 8'h64, 8'h65, 8'h76, 8'h69, 8'h6C, 8'hDE, 8'hAD};
    int base;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) hist[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 hit", 32'(hit), 0);
    check("R1 rule_hits", 32'(rule_hits), 0);
    check("R1 count", 32'(byte_count), 0);

    // R2: data moves, toggle held
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); din = alpha[i % 9];
    end
    settle();
    check("R2 held toggle count", 32'(byte_count), 0);
    check("R2 held toggle hit", 32'(hit), 0);

    // R4: latency of rule 0
    send(8'h62, 0); send(8'h61, 0); send(8'h64, 0);
    @(negedge clk);
    check("R4 after N", 32'(hit), 0);
    @(posedge clk); @(negedge clk);
    check("R4 after N+1", 32'(rule_hits[0]), 0);
    @(posedge clk); @(negedge clk);
    check("R4 after N+2 hit", 32'(hit), 1);
    check("R4 after N+2 rule0", 32'(rule_hits), 3'b001);
    // R7: stays set
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R7 sticky", 32'(hit), 1);
    send(8'h00, 0); settle();
    check_model("R7 sticky model");
    do_clear();
    check("R7 cleared", 32'(hit), 0);

    // R8: clear lands on the recording edge
    send(8'h62, 0); send(8'h61, 0); send(8'h64, 0);
    @(negedge clk); @(posedge clk);
    @(negedge clk); clr = 1'b1;
    @(posedge clk);
    @(negedge clk); clr = 1'b0;
    model_clear();
    check("R8 hit", 32'(hit), 0);
    check("R8 rule_hits", 32'(rule_hits), 0);
    check("R8 count", 32'(byte_count), 0);
    settle();
    check_model("R8 after settle");

    // R9: bytes before clear must not combine
    send(8'h62, 0); send(8'h61, 2); settle();
    do_clear();
    send(8'h64, 0); settle();
    check("R9 stale", 32'(hit), 0);
    check_model("R9 model");
    send(8'hDE, 1); send(8'h00, 0); send(8'hAD, 0); settle();
    check("R9 single-byte window", 32'(rule_hits), 0);

    // R11: wrong order
    do_clear();
    send(8'h64, 0); send(8'h61, 0); send(8'h62, 0); send(8'hAD, 0); send(8'hDE, 0); settle();
    check("R11 reversed", 32'(hit), 0);

    // R5/R6: long gaps, each rule alone
    do_clear();
    send(8'h65, 7); send(8'h76, 30); send(8'h69, 1); send(8'h6C, 55); settle();
    check("R5 gapped rule1", 32'(rule_hits), 3'b010);
    check("R6 combined", 32'(hit), 1);
    do_clear();
    send(8'hDE, 40); send(8'hAD, 40); settle();
    check("R6 rule2 only", 32'(rule_hits), 3'b100);

    // R3: one byte per clock
    do_clear();
    base = 0;
    for (int i = 0; i < 8; i++) send(8'h11, 0);
    @(negedge clk);
    check("R3 back-to-back", 32'(byte_count), base + 7);
    settle();
    check("R3 final", 32'(byte_count), 8);

    // Random bursts against the model (R5, R6, R9)
    do_clear();
    for (int b = 0; b < 60; b++) begin
      int n = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++)
        send(alpha[$urandom % 9], int'($urandom % 4));
      settle();
      check_model("R6 random");
      if (($urandom % 4) == 0) do_clear();
    end

    // R10: saturation
    do_clear();
    for (int i = 0; i < 65540; i++) begin
      @(negedge clk); din = 8'h00; adv_tgl = ~adv_tgl;
      @(posedge clk);
    end
    settle();
    check("R10 saturate", 32'(byte_count), 65535);
    check("R10 no hit", 32'(hit), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule